// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block is the write-side controller of a byte-wide nonvolatile memory model whose sectors hold 128 bytes each. The host drives an active-low strobe bus made of chip enable, write enable and output enable, plus address and data lines. These pins are treated as asynchronous, so they pass through a two-stage synchronizer before the clocked logic sees them. A write strobe is a window in which chip enable and write enable are both low while output enable is high. The address is taken when that window opens and the data byte when it closes. Each byte is placed in a 128-entry sector buffer, and a per-byte flag records which bytes were loaded.

There is no commit command. A load phase ends on its own when no new strobe opens within a fixed number of clocks after the last strobe closed. The sequencer then raises `busy` and runs a program cycle of fixed length. At the start of the cycle the sector is erased, and at the end the buffer is written into a behavioural cell array. Unloaded bytes take the erased value 0xFF, and `gap_fill` reports that this happened. Both time spans are parameters counted in clock ticks so that simulation can scale them down. The number of sectors is also a parameter: a 9-bit sector field gives the full 64K x 8 array.

Top module: `sector_prog_ctrl`

## Requirements
- R1: A byte is loaded only by a strobe window in which ce_n=0, we_n=0 and oe_n=1 hold at once. The address is taken when the window opens and the data when it closes.
- R2: Address bits [6:0] select the byte within a sector. The bits above them select the sector.
- R3: Bytes may be loaded in any order. A second load to the same byte position in one phase overwrites the first.
- R4: A window that opens fewer than WIN_TICKS clocks after the previous window closed keeps the phase open. Otherwise `busy` rises WIN_TICKS+3 clocks after we_n rises on the last load, counting the two synchronizer stages and the edge detector.
- R5: The first accepted load of a phase fixes the sector. Loads addressing another sector during that phase are ignored.
- R6: `busy` stays high for exactly PROG_TICKS clocks. The sector is committed when it falls.
- R7: After a program cycle, unloaded bytes of the sector read 0xFF. `gap_fill` is 1 if any byte was unloaded and 0 if all 128 were loaded.
- R8: A write-enable pulse made while oe_n=0 or while ce_n=1 loads nothing and starts no program cycle.
- R9: Strobes that arrive while `busy` is high change no buffered data and do not open a new phase.
- R10: A read with ce_n=0, oe_n=0 and we_n=1, made while `busy` is low, returns the stored byte two clocks after the pins settle. Otherwise `dout` is 0x00. After reset, every byte reads 0xFF, `busy` is 0 and `gap_fill` is 0.
- R11: A program cycle leaves every other sector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | SEC_BITS+7 | Byte address (sector field over byte field) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when not reading or busy |
| busy | output | 1 | High while the program cycle runs |
| gap_fill | output | 1 | Last program cycle filled unloaded bytes with 0xFF |

## Verification
The bench aims at the exact clock on which the load window closes. A counter that is off by one, or that keeps running while a strobe is still open, would move the rising edge of `busy`. It loads the same byte position twice and also loads in reverse order, which catches a buffer that keeps the first write or depends on arrival order. It sends a load to a foreign sector partway through a phase, and strobes during `busy`, which expose a design that re-locks the sector or lets a late strobe start a second cycle. It also loads a full sector against a partial one: a fill rule that is inverted, or a `gap_fill` flag that is never set, shows up as wrong bytes or a wrong flag value.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int BYTE_BITS    = 7;
  localparam int SECTOR_BYTES = 1 << BYTE_BITS;
  localparam int DATA_W       = 8;
  localparam logic [7:0] ERASED = 8'hFF;

  // byte position inside a sector
  function automatic logic [BYTE_BITS-1:0] byte_of(input logic [31:0] a);
    return a[BYTE_BITS-1:0];
  endfunction

  // sector number of an address
  function automatic logic [31:0] sector_of(input logic [31:0] a);
    return a >> BYTE_BITS;
  endfunction

  // value committed for one byte slot
  function automatic logic [7:0] commit_byte(input logic hit, input logic [7:0] d);
    return hit ? d : ERASED;
  endfunction

  // true on the last tick of a span of lim ticks
  function automatic logic last_tick(input int cnt, input int lim);
    return cnt == lim - 1;
  endfunction
endpackage

// File: rtl/spl_strobe_sync.sv
module spl_strobe_sync #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          ld_start,
  output logic          ld_end,
  output logic          rd_en,
  output logic [AW-1:0] addr_s,
  output logic [7:0]    din_s
);
  logic [2:0]    ctl1, ctl2;   // {ce_n, we_n, oe_n}
  logic [AW-1:0] a1;
  logic [7:0]    d1;
  logic          act, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= 3'b111; ctl2 <= 3'b111;
      a1 <= '0; addr_s <= '0; d1 <= '0; din_s <= '0;
      act_q <= 1'b0;
    end else begin
      ctl1 <= {ce_n, we_n, oe_n};
      ctl2 <= ctl1;
      a1 <= addr; addr_s <= a1;
      d1 <= din;  din_s <= d1;
      act_q <= act;
    end
  end

  assign act      = !ctl2[2] && !ctl2[1] && ctl2[0];
  assign ld_start = act && !act_q;
  assign ld_end   = !act && act_q;
  assign rd_en    = !ctl2[2] && ctl2[1] && !ctl2[0];
endmodule

// File: rtl/spl_sector_buf.sv
module spl_sector_buf import spl_pkg::*; #(
  parameter int AW        = 11,
  parameter int SEC_BITS  = 4,
  parameter int WIN_TICKS = 20
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ld_start,
  input  logic                                   ld_end,
  input  logic [AW-1:0]                          addr_s,
  input  logic [7:0]                             din_s,
  input  logic                                   busy,
  output logic                                   win_done,
  output logic [SEC_BITS-1:0]                    lock_sec,
  output logic [SECTOR_BYTES-1:0][DATA_W-1:0]    buf_q,
  output logic [SECTOR_BYTES-1:0]                mask_q
);
  localparam int CW = $clog2(WIN_TICKS + 1);

  logic                 armed, pend, accept;
  logic [BYTE_BITS-1:0] off_lat;
  logic [CW-1:0]        win_cnt;
  logic [SEC_BITS-1:0]  in_sec;

  assign in_sec   = SEC_BITS'(sector_of(32'(addr_s)));
  assign accept   = ld_start && !busy && (!armed || in_sec == lock_sec);
  assign win_done = armed && !pend && !accept && last_tick(int'(win_cnt), WIN_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; pend <= 1'b0; off_lat <= '0; win_cnt <= '0;
      lock_sec <= '0; buf_q <= '0; mask_q <= '0;
    end else if (accept) begin
      if (!armed) begin
        armed    <= 1'b1;
        lock_sec <= in_sec;
        mask_q   <= '0;
      end
      pend    <= 1'b1;
      off_lat <= byte_of(32'(addr_s));
      win_cnt <= '0;
    end else if (ld_end && pend) begin
      buf_q[off_lat]  <= din_s;
      mask_q[off_lat] <= 1'b1;
      pend    <= 1'b0;
      win_cnt <= '0;
    end else if (win_done) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else if (armed && !pend) begin
      win_cnt <= win_cnt + CW'(1);
    end
  end

  // R4
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < CW'(WIN_TICKS));
  // R5
  sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (!armed || $stable(lock_sec)));
  // R9
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q));
  // R9
  busy_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pend);
endmodule

// File: rtl/spl_prog_timer.sv
module spl_prog_timer import spl_pkg::*; #(
  parameter int PROG_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  output logic busy,
  output logic prog_done
);
  localparam int TW = $clog2(PROG_TICKS + 1);
  logic [TW-1:0] tick;

  assign prog_done = busy && last_tick(int'(tick), PROG_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tick <= '0;
    end else if (win_done) begin
      busy <= 1'b1; tick <= '0;
    end else if (prog_done) begin
      busy <= 1'b0; tick <= '0;
    end else if (busy) begin
      tick <= tick + TW'(1);
    end
  end

  // R6
  fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prog_done));
  // R6
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick < TW'(PROG_TICKS));
endmodule

// File: rtl/spl_cell_array.sv
module spl_cell_array import spl_pkg::*; #(
  parameter int SEC_BITS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                erase,
  input  logic                                commit,
  input  logic [SEC_BITS-1:0]                 sec,
  input  logic [SECTOR_BYTES-1:0][DATA_W-1:0] buf_q,
  input  logic [SECTOR_BYTES-1:0]             mask_q,
  input  logic [SEC_BITS+BYTE_BITS-1:0]       rd_addr,
  output logic [7:0]                          rd_data
);
  localparam int DEPTH = 1 << (SEC_BITS + BYTE_BITS);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
    end else if (erase) begin
      for (int i = 0; i < SECTOR_BYTES; i++)
        cells[{sec, BYTE_BITS'(i)}] <= ERASED;
    end else if (commit) begin
      for (int i = 0; i < SECTOR_BYTES; i++)
        cells[{sec, BYTE_BITS'(i)}] <= commit_byte(mask_q[i], buf_q[i]);
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl import spl_pkg::*; #(
  parameter int SEC_BITS   = 4,
  parameter int WIN_TICKS  = 20,
  parameter int PROG_TICKS = 40,
  localparam int AW        = SEC_BITS + BYTE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          busy,
  output logic          gap_fill
);
  logic                                ld_start, ld_end, rd_en;
  logic [AW-1:0]                       addr_s;
  logic [7:0]                          din_s, rd_data;
  logic                                win_done, prog_done;
  logic [SEC_BITS-1:0]                 lock_sec;
  logic [SECTOR_BYTES-1:0][DATA_W-1:0] buf_q;
  logic [SECTOR_BYTES-1:0]             mask_q;

  spl_strobe_sync #(.AW(AW)) sync_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .ld_start(ld_start), .ld_end(ld_end),
    .rd_en(rd_en), .addr_s(addr_s), .din_s(din_s));

  spl_sector_buf #(.AW(AW), .SEC_BITS(SEC_BITS), .WIN_TICKS(WIN_TICKS)) sbuf_i (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_end(ld_end),
    .addr_s(addr_s), .din_s(din_s), .busy(busy), .win_done(win_done),
    .lock_sec(lock_sec), .buf_q(buf_q), .mask_q(mask_q));

  spl_prog_timer #(.PROG_TICKS(PROG_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .busy(busy),
    .prog_done(prog_done));

  spl_cell_array #(.SEC_BITS(SEC_BITS)) cells_i (
    .clk(clk), .rst_n(rst_n), .erase(win_done), .commit(prog_done),
    .sec(lock_sec), .buf_q(buf_q), .mask_q(mask_q), .rd_addr(addr_s),
    .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_fill <= 1'b0;
    else if (prog_done) gap_fill <= ~&mask_q;
  end

  assign dout = (rd_en && !busy) ? rd_data : 8'h00;

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dout == 8'h00);
  // R6
  rise_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_done));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> !busy);
  // R7
  flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(prog_done) |-> $stable(gap_fill));
endmodule

// File: tb/sector_prog_ctrl_tb_top.sv
module sector_prog_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SECB  = 4;
  localparam int WIN   = 20;
  localparam int PROG  = 40;
  localparam int AW    = SECB + 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy, gap_fill;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_prog_ctrl #(.SEC_BITS(SECB), .WIN_TICKS(WIN), .PROG_TICKS(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .gap_fill(gap_fill));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   p_ce[2], p_we[2], p_oe[2];
  int   p_a[2], p_d[2];
  bit   was_on, phase_open, in_flight, m_busy, m_gap;
  int   held_sec, held_off, quiet, ticks;
  int   pos_q[$], val_q[$];
  logic [7:0] image [DEPTH];
  int   exp_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        p_ce[i] = 1; p_we[i] = 1; p_oe[i] = 1; p_a[i] = 0; p_d[i] = 0;
      end
      was_on = 0; phase_open = 0; in_flight = 0; m_busy = 0; m_gap = 0;
      held_sec = 0; held_off = 0; quiet = 0; ticks = 0;
      pos_q.delete(); val_q.delete();
      for (int i = 0; i < DEPTH; i++) image[i] = 8'hFF;
      exp_dout = 0;
    end else begin
      automatic bit on    = !p_ce[1] && !p_we[1] && p_oe[1];
      automatic bit opens = on && !was_on;
      automatic bit shuts = !on && was_on;
      automatic int s_in  = p_a[1] / 128;
      automatic bit take  = opens && !m_busy && (!phase_open || s_in == held_sec);
      automatic bit close = phase_open && !in_flight && !take && quiet == WIN - 1;
      automatic bit fin   = m_busy && ticks == PROG - 1;
      if (take) begin
        if (!phase_open) begin
          phase_open = 1; held_sec = s_in; pos_q.delete(); val_q.delete();
        end
        in_flight = 1; held_off = p_a[1] % 128; quiet = 0;
      end else if (shuts && in_flight) begin
        pos_q.push_back(held_off); val_q.push_back(p_d[1]);
        in_flight = 0; quiet = 0;
      end else if (close) begin
        phase_open = 0; quiet = 0;
      end else if (phase_open && !in_flight) quiet++;

      if (close) begin m_busy = 1; ticks = 0; end
      else if (fin) begin
        automatic bit seen [128];
        automatic int hits = 0;
        m_busy = 0;
        for (int i = 0; i < 128; i++) begin seen[i] = 0; image[held_sec*128+i] = 8'hFF; end
        foreach (pos_q[k]) begin
          image[held_sec*128+pos_q[k]] = val_q[k][7:0];
          if (!seen[pos_q[k]]) hits++;
          seen[pos_q[k]] = 1;
        end
        m_gap = (hits < 128);
      end else if (m_busy) ticks++;

      was_on = on;
      p_ce[1] = p_ce[0]; p_we[1] = p_we[0]; p_oe[1] = p_oe[0];
      p_a[1] = p_a[0]; p_d[1] = p_d[0];
      p_ce[0] = ce_n; p_we[0] = we_n; p_oe[0] = oe_n; p_a[0] = int'(addr); p_d[0] = int'(din);
      exp_dout = (!p_ce[1] && !p_oe[1] && p_we[1] && !m_busy) ? int'(image[p_a[1]]) : 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 busy vs model", int'(busy), int'(m_busy));
      chk("R10 dout vs model", int'(dout), exp_dout);
      chk("R7 gap_fill vs model", int'(gap_fill), int'(m_gap));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse(input int a, input int d, input bit ce_v, input bit oe_v);
    @(negedge clk); addr = AW'(a); din = d[7:0]; ce_n = ce_v; oe_n = oe_v; we_n = 1;
    @(negedge clk); we_n = 0;
    repeat (3) @(negedge clk);
    we_n = 1;
  endtask

  task automatic ld(input int sec, input int off, input int d);
    pulse(sec*128 + off, d, 0, 1);
    @(negedge clk);
  endtask

  task automatic rd(input int sec, input int off, output int v);
    @(negedge clk); addr = AW'(sec*128 + off); ce_n = 0; oe_n = 0; we_n = 1;
    repeat (3) @(negedge clk);
    v = int'(dout);
    @(negedge clk); oe_n = 1;
  endtask

  task automatic wait_idle();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset gap_fill", int'(gap_fill), 0);
    chk("R10 idle dout", int'(dout), 0);
    rd(0, 0, v); chk("R10 reset contents", v, 8'hFF);

    // phase in sector 1, out of order, with an overwrite
    ld(1, 5, 8'hA5); ld(1, 0, 8'h3C); ld(1, 127, 8'h81); ld(1, 5, 8'h5A);
    while (!busy) @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R6 busy length", n, PROG);
    rd(1, 5, v);   chk("R3 overwrite keeps last", v, 8'h5A);
    rd(1, 0, v);   chk("R2 byte 0 of sector 1", v, 8'h3C);
    rd(1, 127, v); chk("R2 byte 127 of sector 1", v, 8'h81);
    rd(1, 6, v);   chk("R7 unloaded byte erased", v, 8'hFF);
    chk("R7 gap flag set", int'(gap_fill), 1);

    // foreign sector mid-phase
    ld(2, 3, 8'h11); ld(3, 3, 8'h22);
    wait_idle();
    rd(2, 3, v); chk("R5 locked sector written", v, 8'h11);
    rd(3, 3, v); chk("R5 foreign sector ignored", v, 8'hFF);
    rd(1, 5, v); chk("R11 other sector intact", v, 8'h5A);

    // inhibit conditions
    pulse(4*128 + 1, 8'h77, 0, 0);
    repeat (WIN + 10) @(negedge clk);
    chk("R8 oe low inhibits", int'(busy), 0);
    pulse(4*128 + 1, 8'h77, 1, 1);
    repeat (WIN + 10) @(negedge clk);
    chk("R8 ce high inhibits", int'(busy), 0);
    rd(4, 1, v); chk("R8 nothing stored", v, 8'hFF);

    // exact window timing
    pulse(4*128 + 9, 8'h99, 0, 1);
    repeat (WIN - 6) @(negedge clk);
    chk("R4 open within window", int'(busy), 0);
    pulse(4*128 + 10, 8'hAA, 0, 1);
    repeat (WIN + 2) @(negedge clk);
    chk("R4 busy not yet", int'(busy), 0);
    @(negedge clk);
    chk("R4 busy on time", int'(busy), 1);
    // strobe during busy
    pulse(4*128 + 9, 8'hEE, 0, 1);
    while (busy) @(negedge clk);
    repeat (WIN + 10) @(negedge clk);
    chk("R9 no new phase", int'(busy), 0);
    rd(4, 9, v);  chk("R9 busy strobe ignored", v, 8'h99);
    rd(4, 10, v); chk("R4 second byte stored", v, 8'hAA);

    // full sector, descending order
    for (int i = 127; i >= 0; i--) ld(5, i, i ^ 8'h5C);
    while (!busy) @(negedge clk);
    @(negedge clk); addr = AW'(5*128); ce_n = 0; oe_n = 0; we_n = 1;
    repeat (3) @(negedge clk);
    chk("R10 read during busy", int'(dout), 0);
    oe_n = 1;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R7 full sector no gap", int'(gap_fill), 0);
    rd(5, 0, v);   chk("R3 full byte 0", v, 8'h5C);
    rd(5, 64, v);  chk("R3 full byte 64", v, 64 ^ 8'h5C);
    rd(5, 127, v); chk("R1 full byte 127", v, 127 ^ 8'h5C);
    rd(2, 3, v);   chk("R11 sector 2 intact", v, 8'h11);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule